// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block is the part of a small 32-bit core that decides, on each clock, whether a pending interrupt should divert the instruction stream. There are two request lines: a normal class and a fast class. The block looks at the core's current status word (mode field plus two disable bits), the address of the next instruction, and a select bit that places the vector table either at the bottom of the address space or at 0xFFFF0000. When it accepts a request, it issues one entry event. That event carries the redirected program counter, the status word for the handler, and the return address and status it has stored for the handler's mode.

Each handler mode has its own stored return address and stored status. A fast handler that preempts a normal handler therefore does not disturb the normal handler's context. A return strobe brings back the program counter and status that were stored for the current handler mode. The surrounding core loads the new program counter and status from the outputs in the cycle the valid pulse appears.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `entry_vld_o` and `ret_vld_o` are 0 and all data outputs are 0.
- R2: A normal request is not taken while status bit 7 (normal disable) is 1.
- R3: A fast request is not taken while status bit 6 (fast disable) is 1.
- R4: The vector base is 0x00000000 when `hivec_i` is 0 and 0xFFFF0000 when it is 1. Normal entries redirect to base+0x18 and fast entries to base+0x1C.
- R5: On entry, `saved_ret_o` equals the sampled `next_pc_i` and `saved_status_o` equals the sampled status. `new_status_o` is the sampled status with bits [4:0] replaced by the mode code (fast 0x11, normal 0x12) and bit 7 set; a fast entry also sets bit 6. All other bits are unchanged.
- R6: When both requests are pending and both are enabled, the fast request is taken and `entry_fast_o` is 1.
- R7: In normal-handler mode (0x12) only a fast request can enter. In fast-handler mode (0x11) no request enters, whatever the disable bits are.
- R8: A return strobe in mode 0x11 or 0x12 gives a one-cycle `ret_vld_o` pulse, with `new_pc_o` and `new_status_o` equal to the values stored at the last entry into that mode. A return strobe in any other mode (user 0x10, supervisor 0x13) is ignored.
- R9: Inputs are sampled on a rising edge and the event appears in the cycle after that edge. A request that is removed before any edge samples it produces no entry. Entry and return never signal in the same cycle.
- R10: When a valid return strobe and an enabled request arrive in the same cycle, the return is taken and no entry is made.
- R11: The normal-mode and fast-mode stores are separate. After a fast entry nested inside a normal handler, the fast return restores the normal handler's context, and the following normal return restores the original context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 1 | Normal-class request, level-sensitive |
| fiq_req_i | input | 1 | Fast-class request, level-sensitive |
| ret_i | input | 1 | Return-from-handler strobe |
| hivec_i | input | 1 | Vector table at high base when 1 |
| status_i | input | 32 | Current status word: mode [4:0], fast disable bit 6, normal disable bit 7 |
| next_pc_i | input | 32 | Address of the next instruction |
| entry_vld_o | output | 1 | One-cycle entry event |
| entry_fast_o | output | 1 | Entry was of the fast class |
| ret_vld_o | output | 1 | One-cycle return event |
| new_pc_o | output | 32 | Vector address on entry, restored address on return |
| new_status_o | output | 32 | Handler status on entry, restored status on return |
| saved_ret_o | output | 32 | Return address stored at the last entry |
| saved_status_o | output | 32 | Status word stored at the last entry |

## Verification
Assertions run on every cycle. They check that no entry happens while its class is disabled, that nothing enters from fast mode, that only a fast entry leaves normal mode, that a fast request which is pending and enabled always wins, that entry and return never coincide, that a valid return is never lost to a request, and that each mode's store changes only when that mode is entered. The redirected addresses under both vector bases, the exact status rewrite, the nested entry and unwind sequence, and the handling of a request that comes and goes between two edges show up only in the bench's directed scenarios.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam int BIT_F = 6;
  localparam int BIT_I = 7;
  localparam int MODE_W = 5;
  localparam int NBANK = 2;
  localparam int BANK_IRQ = 0;
  localparam int BANK_FIQ = 1;

  typedef enum logic [1:0] {EV_NONE, EV_IRQ, EV_FIQ, EV_RET} ev_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic              irq_req,
  input  logic              fiq_req,
  input  logic              ret_req,
  input  logic [MODE_W-1:0] mode,
  input  logic              dis_i,
  input  logic              dis_f,
  output ev_e               ev,
  output logic              rd_sel
);
  logic in_fiq, in_irq, fiq_ok, irq_ok, ret_ok;

  always_comb begin
    in_fiq = (mode == MODE_FIQ);
    in_irq = (mode == MODE_IRQ);
    // a fast handler can be preempted by nothing; a normal handler only by the fast class
    fiq_ok = fiq_req && !dis_f && !in_fiq;
    irq_ok = irq_req && !dis_i && !in_fiq && !in_irq;
    ret_ok = ret_req && (in_fiq || in_irq);
    rd_sel = in_fiq;
    if (ret_ok)      ev = EV_RET;
    else if (fiq_ok) ev = EV_FIQ;
    else if (irq_ok) ev = EV_IRQ;
    else             ev = EV_NONE;
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
  parameter int          AW      = 32,
  parameter logic [31:0] HI_BASE = 32'hFFFF_0000,
  parameter logic [7:0]  OFF_IRQ = 8'h18,
  parameter logic [7:0]  OFF_FIQ = 8'h1C
) (
  input  logic          hivec,
  input  logic          fast,
  output logic [AW-1:0] vec_addr
);
  logic [AW-1:0] base, off;

  always_comb begin
    base     = hivec ? AW'(HI_BASE) : '0;
    off      = fast ? AW'(OFF_FIQ) : AW'(OFF_IRQ);
    vec_addr = base + off;
  end
endmodule

// File: rtl/exc_bank.sv
module exc_bank
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_ret,
  input  logic [SW-1:0] wr_status,
  input  logic          rd_sel,
  output logic [AW-1:0] rd_ret,
  output logic [SW-1:0] rd_status
);
  logic [AW-1:0] ret_q    [NBANK];
  logic [SW-1:0] status_q [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic          ld;
    logic [AW-1:0] ret_d;
    logic [SW-1:0] status_d;

    always_comb begin
      ld       = wr_en && (int'(wr_sel) == g);
      ret_d    = ld ? wr_ret : ret_q[g];
      status_d = ld ? wr_status : status_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ret_q[g]    <= '0;
        status_q[g] <= '0;
      end else begin
        ret_q[g]    <= ret_d;
        status_q[g] <= status_d;
      end
    end

    // each mode's store moves only when that mode is entered
    assert_bank_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && int'(wr_sel) == g) |=> ($stable(ret_q[g]) && $stable(status_q[g])));
  end

  always_comb begin
    rd_ret    = rd_sel ? ret_q[BANK_FIQ]    : ret_q[BANK_IRQ];
    rd_status = rd_sel ? status_q[BANK_FIQ] : status_q[BANK_IRQ];
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int          AW      = 32,
  parameter int          SW      = 32,
  parameter logic [31:0] HI_BASE = 32'hFFFF_0000,
  parameter logic [7:0]  OFF_IRQ = 8'h18,
  parameter logic [7:0]  OFF_FIQ = 8'h1C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req_i,
  input  logic          fiq_req_i,
  input  logic          ret_i,
  input  logic          hivec_i,
  input  logic [SW-1:0] status_i,
  input  logic [AW-1:0] next_pc_i,
  output logic          entry_vld_o,
  output logic          entry_fast_o,
  output logic          ret_vld_o,
  output logic [AW-1:0] new_pc_o,
  output logic [SW-1:0] new_status_o,
  output logic [AW-1:0] saved_ret_o,
  output logic [SW-1:0] saved_status_o
);
  ev_e           ev;
  logic          rd_sel, is_entry, is_fast, load_out;
  logic [AW-1:0] vec_addr, bank_ret;
  logic [SW-1:0] bank_status, entry_status;

  logic          entry_vld_q, entry_fast_q, ret_vld_q;
  logic          entry_fast_d;
  logic [AW-1:0] new_pc_q, new_pc_d, saved_ret_q, saved_ret_d;
  logic [SW-1:0] new_status_q, new_status_d, saved_status_q, saved_status_d;

  exc_arbiter u_arb (
    .irq_req (irq_req_i),
    .fiq_req (fiq_req_i),
    .ret_req (ret_i),
    .mode    (status_i[MODE_W-1:0]),
    .dis_i   (status_i[BIT_I]),
    .dis_f   (status_i[BIT_F]),
    .ev      (ev),
    .rd_sel  (rd_sel)
  );

  always_comb begin
    is_fast  = (ev == EV_FIQ);
    is_entry = (ev == EV_IRQ) || is_fast;
    load_out = (ev != EV_NONE);
  end

  exc_vector #(
    .AW(AW), .HI_BASE(HI_BASE), .OFF_IRQ(OFF_IRQ), .OFF_FIQ(OFF_FIQ)
  ) u_vec (
    .hivec    (hivec_i),
    .fast     (is_fast),
    .vec_addr (vec_addr)
  );

  exc_bank #(.AW(AW), .SW(SW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (is_entry),
    .wr_sel    (is_fast),
    .wr_ret    (next_pc_i),
    .wr_status (status_i),
    .rd_sel    (rd_sel),
    .rd_ret    (bank_ret),
    .rd_status (bank_status)
  );

  // status handed to the handler: new mode, normal class masked, fast class also masked on fast entry
  always_comb begin
    entry_status               = status_i;
    entry_status[MODE_W-1:0]   = is_fast ? MODE_FIQ : MODE_IRQ;
    entry_status[BIT_I]        = 1'b1;
    if (is_fast) entry_status[BIT_F] = 1'b1;
  end

  // next-state values with explicit clock enables
  always_comb begin
    new_pc_d       = new_pc_q;
    new_status_d   = new_status_q;
    saved_ret_d    = saved_ret_q;
    saved_status_d = saved_status_q;
    entry_fast_d   = entry_fast_q;
    if (load_out) begin
      new_pc_d     = (ev == EV_RET) ? bank_ret : vec_addr;
      new_status_d = (ev == EV_RET) ? bank_status : entry_status;
    end
    if (is_entry) begin
      saved_ret_d    = next_pc_i;
      saved_status_d = status_i;
      entry_fast_d   = is_fast;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_vld_q    <= 1'b0;
      entry_fast_q   <= 1'b0;
      ret_vld_q      <= 1'b0;
      new_pc_q       <= '0;
      new_status_q   <= '0;
      saved_ret_q    <= '0;
      saved_status_q <= '0;
    end else begin
      entry_vld_q    <= is_entry;
      entry_fast_q   <= entry_fast_d;
      ret_vld_q      <= (ev == EV_RET);
      new_pc_q       <= new_pc_d;
      new_status_q   <= new_status_d;
      saved_ret_q    <= saved_ret_d;
      saved_status_q <= saved_status_d;
    end
  end

  always_comb begin
    entry_vld_o    = entry_vld_q;
    entry_fast_o   = entry_fast_q;
    ret_vld_o      = ret_vld_q;
    new_pc_o       = new_pc_q;
    new_status_o   = new_status_q;
    saved_ret_o    = saved_ret_q;
    saved_status_o = saved_status_q;
  end

  assert_irq_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_vld_o && !entry_fast_o) |-> !$past(status_i[BIT_I]));

  assert_fiq_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_vld_o && entry_fast_o) |-> !$past(status_i[BIT_F]));

  assert_fast_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_vld_o && $past(fiq_req_i && !status_i[BIT_F])) |-> entry_fast_o);

  assert_no_fast_nest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    entry_vld_o |-> ($past(status_i[MODE_W-1:0]) != MODE_FIQ));

  assert_irq_nest_fast_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_vld_o && $past(status_i[MODE_W-1:0]) == MODE_IRQ) |-> entry_fast_o);

  assert_ret_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld_o |-> ($past(status_i[MODE_W-1:0]) == MODE_FIQ || $past(status_i[MODE_W-1:0]) == MODE_IRQ));

  assert_one_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(entry_vld_o && ret_vld_o));

  assert_ret_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ret_i) && ($past(status_i[MODE_W-1:0]) == MODE_FIQ || $past(status_i[MODE_W-1:0]) == MODE_IRQ))
      |-> (ret_vld_o && !entry_vld_o));
endmodule

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_req_i, fiq_req_i, ret_i, hivec_i;
  logic [31:0] status_i, next_pc_i;
  logic        entry_vld_o, entry_fast_o, ret_vld_o;
  logic [31:0] new_pc_o, new_status_o, saved_ret_o, saved_status_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .fiq_req_i(fiq_req_i),
    .ret_i(ret_i), .hivec_i(hivec_i), .status_i(status_i), .next_pc_i(next_pc_i),
    .entry_vld_o(entry_vld_o), .entry_fast_o(entry_fast_o), .ret_vld_o(ret_vld_o),
    .new_pc_o(new_pc_o), .new_status_o(new_status_o),
    .saved_ret_o(saved_ret_o), .saved_status_o(saved_status_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // one edge; inputs change 1 ns after the edge and outputs are read there
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    irq_req_i = 0; fiq_req_i = 0; ret_i = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; idle(); hivec_i = 0; status_i = 32'h10; next_pc_i = 0;
    repeat (3) step();
    chk("R1 entry_vld in reset", {31'b0, entry_vld_o}, 0);
    chk("R1 new_pc in reset", new_pc_o, 0);
    rst_n = 1;
    step();
    chk("R1 ret_vld after reset", {31'b0, ret_vld_o}, 0);
    chk("R1 saved_status after reset", saved_status_o, 0);
  endtask

  task automatic t_masks();
    status_i = 32'h90; irq_req_i = 1;
    step();
    chk("R2 normal masked", {31'b0, entry_vld_o}, 0);
    idle(); status_i = 32'h50; fiq_req_i = 1;
    step();
    chk("R3 fast masked", {31'b0, entry_vld_o}, 0);
    idle(); step();
  endtask

  task automatic t_irq_low();
    status_i = 32'h8000_0010; next_pc_i = 32'h0000_0400; hivec_i = 0; irq_req_i = 1;
    step();
    idle();
    chk("R9 entry pulse", {31'b0, entry_vld_o}, 1);
    chk("R4 low normal vector", new_pc_o, 32'h18);
    chk("R5 normal status", new_status_o, 32'h8000_0092);
    chk("R5 saved ret", saved_ret_o, 32'h400);
    chk("R5 saved status", saved_status_o, 32'h8000_0010);
    status_i = 32'h10; step();
    chk("R9 single pulse", {31'b0, entry_vld_o}, 0);
  endtask

  task automatic t_fiq_high_priority();
    status_i = 32'h13; next_pc_i = 32'h0000_1234; hivec_i = 1; irq_req_i = 1; fiq_req_i = 1;
    step();
    idle();
    chk("R6 fast chosen", {31'b0, entry_fast_o}, 1);
    chk("R4 high fast vector", new_pc_o, 32'hFFFF_001C);
    chk("R5 fast status", new_status_o, 32'hD1);
    status_i = 32'h10; irq_req_i = 1; hivec_i = 1;
    step(); idle();
    chk("R4 high normal vector", new_pc_o, 32'hFFFF_0018);
    hivec_i = 0; status_i = 32'h10; step();
  endtask

  task automatic t_nest();
    status_i = 32'h10; next_pc_i = 32'h100; irq_req_i = 1;
    step(); idle();
    chk("R11 outer entry", new_status_o, 32'h92);
    status_i = 32'h12; irq_req_i = 1; next_pc_i = 32'h1500;
    step(); idle();
    chk("R7 normal cannot nest normal", {31'b0, entry_vld_o}, 0);
    status_i = 32'h92; next_pc_i = 32'h2000; fiq_req_i = 1;
    step();
    chk("R7 fast nests in normal", {31'b0, entry_vld_o & entry_fast_o}, 1);
    chk("R11 inner saved status", saved_status_o, 32'h92);
    status_i = 32'h11; irq_req_i = 1; fiq_req_i = 1;
    step(); idle();
    chk("R7 nothing nests in fast", {31'b0, entry_vld_o}, 0);
    status_i = 32'hD1; ret_i = 1;
    step(); idle();
    chk("R8 fast return pulse", {31'b0, ret_vld_o}, 1);
    chk("R11 fast return pc", new_pc_o, 32'h2000);
    chk("R11 fast return status", new_status_o, 32'h92);
    status_i = 32'h92; ret_i = 1;
    step(); idle();
    chk("R11 normal return pc", new_pc_o, 32'h100);
    chk("R11 normal return status", new_status_o, 32'h10);
    status_i = 32'h10; step();
    chk("R8 return pulse ends", {31'b0, ret_vld_o}, 0);
  endtask

  task automatic t_ret_ignored();
    status_i = 32'h10; ret_i = 1;
    step(); idle();
    chk("R8 return ignored in user", {31'b0, ret_vld_o}, 0);
    chk("R8 outputs untouched", new_pc_o, 32'h100);
    status_i = 32'h13; ret_i = 1;
    step(); idle();
    chk("R8 return ignored in supervisor", {31'b0, ret_vld_o}, 0);
  endtask

  task automatic t_ret_vs_req();
    status_i = 32'h10; next_pc_i = 32'h300; irq_req_i = 1;
    step(); idle();
    status_i = 32'h12; ret_i = 1; fiq_req_i = 1;
    step(); idle();
    chk("R10 return wins", {30'b0, ret_vld_o, entry_vld_o}, 32'b10);
    chk("R10 return pc", new_pc_o, 32'h300);
    status_i = 32'h10; step();
  endtask

  task automatic t_drop();
    status_i = 32'h10;
    @(negedge clk); irq_req_i = 1; #1 irq_req_i = 0;
    step();
    chk("R9 unsampled pulse not taken", {31'b0, entry_vld_o}, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_masks();
    t_irq_low();
    t_fiq_high_priority();
    t_nest();
    t_ret_ignored();
    t_ret_vs_req();
    t_drop();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule